// File: doc/BRIEF.md
# Overlay Window Placement and Select

This block sits beside the scan-out counters of a display pipeline. For every base-plane pixel it decides two things: whether the pixel lies inside a rectangular overlay window, and whether the overlay pixel or the base pixel goes to the output. The window is set up through a packed 32-bit placement word, together with the overlay width and height, a stacking bit and an enable bit. The placement word holds the start column, the start row and the colour format.

Every configuration write is checked before it is used. The checks cover an unknown colour format, a start column that does not fall on a 32-bit word boundary, a line length that is not a whole number of words, and a rectangle that does not fit inside the base plane. The alignment checks depend on the colour format. A write that passes the checks is held as pending and is copied to the live window at the next frame start. A write that fails the checks leaves the live window and the pending window unchanged, and it records which checks failed in a sticky flag vector. The overlay never pans horizontally, so its line length is always its visible width.

The select result is registered. It appears one clock after the pixel coordinates, together with a delayed copy of the pixel-valid strobe.

Top module: `ovl_window_sel`

## Requirements
- R1: Fields of `cfg_place`: bits 9:0 give the start row, bits 19:10 give the start column, and bits 22:20 give the format code. Bits 31:23 have no effect.
- R2: The format codes are 0 = RGB at 16 bpp, 1 = packed YUV444 at 24 bpp, 2 = planar YUV444 at 24 bpp, 3 = planar YUV422 at 16 bpp and 4 = planar YUV420 at 12 bpp. A write with code 5, 6 or 7 is rejected and sets `cfg_err[0]`. When the code is invalid, the two alignment flags stay clear.
- R3: The start column must be a multiple of 2 for codes 0 and 3, a multiple of 4 for codes 1 and 2, and a multiple of 8 for code 4. Otherwise the write is rejected and sets `cfg_err[1]`.
- R4: The width must be a multiple of 2 for code 0, of 4 for codes 1 and 2, of 8 for code 3 and of 16 for code 4. These are the sizes of the narrowest plane. Otherwise the write is rejected and sets `cfg_err[2]`.
- R5: The write is rejected and sets `cfg_err[3]` if any of these holds: start column + width > `base_width`, start row + height > `base_height`, width is zero, or height is zero. A rectangle that ends exactly on the base edge is accepted.
- R6: A rejected write changes neither the live window nor the pending window. `cfg_err` keeps its value until the next `cfg_wr`. An accepted write clears `cfg_err` to 0.
- R7: An accepted window becomes live at the clock edge on which `frame_start` is high. Pixels presented in later cycles use the new window. Pixels presented before that edge use the old window.
- R8: `in_window` is 1 one cycle after a valid pixel when all of these hold: the live window is enabled, x0 ≤ `pix_x` < x0 + width, and y0 ≤ `pix_y` < y0 + height. In every other case it is 0.
- R9: `sel_overlay` equals `in_window` when the window is stacked above the base. When the window is below the base, `sel_overlay` equals `in_window` AND `pix_base_clear` of the same pixel.
- R10: `pix_valid_out` is `pix_valid_in` delayed by exactly one clock.
- R11: After reset, no window is live or pending, `cfg_err` is 0, and all pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_place | input | 32 | Placement word (row, column, format) |
| cfg_width | input | 11 | Overlay width in pixels |
| cfg_height | input | 11 | Overlay height in lines |
| cfg_above | input | 1 | 1 = overlay above base, 0 = below |
| cfg_enable | input | 1 | Window enable |
| base_width | input | 11 | Base plane width in pixels |
| base_height | input | 11 | Base plane height in lines |
| frame_start | input | 1 | Frame boundary strobe; pending window goes live here |
| pix_valid_in | input | 1 | Pixel coordinates valid |
| pix_x | input | 10 | Scanned column |
| pix_y | input | 10 | Scanned line |
| pix_base_clear | input | 1 | Base pixel is see-through at this position |
| pix_valid_out | output | 1 | Delayed pixel valid |
| in_window | output | 1 | Pixel lies in the live window |
| sel_overlay | output | 1 | Show the overlay pixel |
| cfg_err | output | 4 | Sticky reject flags: bit0 format, bit1 start column, bit2 length, bit3 bounds |

## Verification
The bench probes the pixels just inside and just outside each window edge. A design with an off-by-one compare would show a window one pixel too wide or too narrow. It uses per-format alignment cases that are valid for one format and invalid for another, such as width 24 under YUV420 or width 12 under YUV422. A design that used total bits per pixel instead of the narrowest plane would accept these widths. It checks a rectangle that ends exactly on the base edge and one that extends two pixels past it, which exposes a wrong comparison operator. It checks that a probe made between an accepted write and the next frame start still sees the old window, and that rejected writes leave the live window in place. A design that applied writes at once, or stored rejected values, would move the window at the wrong time.

// File: rtl/ovl_pkg.sv
// Package: shared widths, format codes, window record and the per-format
// alignment masks used by the overlay placement block.
// Assumes: the placement word layout is fixed at 10-bit coordinates.
package ovl_pkg;
    localparam int unsigned COORD_W = 10;
    localparam int unsigned SIZE_W  = COORD_W + 1;
    localparam int unsigned FMT_W   = 3;
    localparam int unsigned Y_LSB   = 0;
    localparam int unsigned X_LSB   = COORD_W;
    localparam int unsigned F_LSB   = 2 * COORD_W;

    typedef enum logic [FMT_W-1:0] {
        FMT_RGB       = 3'd0,
        FMT_YUV444_PK = 3'd1,
        FMT_YUV444_PL = 3'd2,
        FMT_YUV422_PL = 3'd3,
        FMT_YUV420_PL = 3'd4
    } ovl_fmt_e;

    typedef struct packed {
        logic               en;
        logic               above;
        logic [COORD_W-1:0] x0;
        logic [COORD_W-1:0] y0;
        logic [SIZE_W-1:0]  w;
        logic [SIZE_W-1:0]  h;
    } win_t;

    typedef struct packed {
        logic bounds;
        logic len;
        logic xalign;
        logic fmt;
    } err_t;

    // Low-bit mask a start column must clear to sit on a 32-bit word.
    function automatic logic [3:0] start_mask(input logic [FMT_W-1:0] code);
        case (code)
            FMT_RGB, FMT_YUV422_PL:        start_mask = 4'd1;
            FMT_YUV444_PK, FMT_YUV444_PL:  start_mask = 4'd3;
            FMT_YUV420_PL:                 start_mask = 4'd7;
            default:                       start_mask = 4'd0;
        endcase
    endfunction

    // Low-bit mask a width must clear so the narrowest plane fills whole words.
    function automatic logic [3:0] len_mask(input logic [FMT_W-1:0] code);
        case (code)
            FMT_RGB:                       len_mask = 4'd1;
            FMT_YUV444_PK, FMT_YUV444_PL:  len_mask = 4'd3;
            FMT_YUV422_PL:                 len_mask = 4'd7;
            FMT_YUV420_PL:                 len_mask = 4'd15;
            default:                       len_mask = 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/ovl_cfg_check.sv
// Module: decodes a placement word into a candidate window and evaluates
// the format, start alignment, line length and bounds checks.
// Assumes: purely combinational; the caller registers the result.
module ovl_cfg_check
    import ovl_pkg::*;
(
    input  logic [31:0]       place,
    input  logic [SIZE_W-1:0] width,
    input  logic [SIZE_W-1:0] height,
    input  logic              above,
    input  logic              enable,
    input  logic [SIZE_W-1:0] base_w,
    input  logic [SIZE_W-1:0] base_h,
    output win_t              cand,
    output err_t              err
);
    logic [FMT_W-1:0]   code;
    logic               fmt_bad;
    logic [SIZE_W:0]    x_end;
    logic [SIZE_W:0]    y_end;

    // Field extraction and candidate window assembly.
    always_comb begin
        code       = place[F_LSB +: FMT_W];
        fmt_bad    = (code > FMT_YUV420_PL);
        cand.en    = enable;
        cand.above = above;
        cand.x0    = place[X_LSB +: COORD_W];
        cand.y0    = place[Y_LSB +: COORD_W];
        cand.w     = width;
        cand.h     = height;
    end

    // Validity checks, alignment ones only for a known format.
    always_comb begin
        x_end      = {2'b00, cand.x0} + {1'b0, width};
        y_end      = {2'b00, cand.y0} + {1'b0, height};
        err.fmt    = fmt_bad;
        err.xalign = !fmt_bad && |(cand.x0[3:0] & start_mask(code));
        err.len    = !fmt_bad && |(width[3:0] & len_mask(code));
        err.bounds = (x_end > {1'b0, base_w}) || (y_end > {1'b0, base_h}) ||
                     (width == '0) || (height == '0);
    end
endmodule

// File: rtl/ovl_cfg_regs.sv
// Module: holds the pending and live windows and the sticky reject flags.
// Assumes: cfg_wr and frame_start are single-cycle strobes; a pending
// window moves to live on frame_start, a later accepted write re-arms it.
module ovl_cfg_regs
    import ovl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  win_t cand,
    input  err_t err_in,
    input  logic frame_start,
    output win_t live,
    output err_t err_flags
);
    win_t pend;
    logic pend_vld;

    // Pending capture, frame-boundary promotion and sticky error update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= '0;
            pend_vld  <= 1'b0;
            live      <= '0;
            err_flags <= '0;
        end else begin
            if (frame_start && pend_vld) begin
                live     <= pend;
                pend_vld <= 1'b0;
            end
            if (cfg_wr) begin
                err_flags <= err_in;
                if (err_in == '0) begin
                    pend     <= cand;
                    pend_vld <= 1'b1;
                end
            end
        end
    end

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(err_flags));
    assert_reject_keeps_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (err_in != '0)) |=> $stable(pend));
    assert_live_frame_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(live));
endmodule

// File: rtl/ovl_pix_select.sv
// Module: compares the scanned pixel with the live window and registers
// the hit, the overlay select and the delayed valid strobe.
// Assumes: coordinates are meaningful only while pix_valid_in is high.
module ovl_pix_select
    import ovl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  win_t               live,
    input  logic               pix_valid_in,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic               pix_base_clear,
    output logic               pix_valid_out,
    output logic               in_window,
    output logic               sel_overlay
);
    logic            hit;
    logic [SIZE_W:0] x_lim;
    logic [SIZE_W:0] y_lim;

    // Window membership test on the current pixel.
    always_comb begin
        x_lim = {2'b00, live.x0} + {1'b0, live.w};
        y_lim = {2'b00, live.y0} + {1'b0, live.h};
        hit   = pix_valid_in && live.en &&
                (pix_x >= live.x0) && ({2'b00, pix_x} < x_lim) &&
                (pix_y >= live.y0) && ({2'b00, pix_y} < y_lim);
    end

    // One-cycle output stage for valid, hit and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid_out <= 1'b0;
            in_window     <= 1'b0;
            sel_overlay   <= 1'b0;
        end else begin
            pix_valid_out <= pix_valid_in;
            in_window     <= hit;
            sel_overlay   <= hit && (live.above || pix_base_clear);
        end
    end

    assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_in |=> pix_valid_out);
    assert_idle_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_in |=> !pix_valid_out);
    assert_sel_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_overlay |-> in_window);
    assert_hit_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_window |-> pix_valid_out);
endmodule

// File: rtl/ovl_window_sel.sv
// Module: top of the overlay placement and select block; checks window
// writes, applies them at frame start and selects overlay or base per pixel.
// Assumes: base plane size is held stable while configuration is written.
module ovl_window_sel
    import ovl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [31:0]        cfg_place,
    input  logic [SIZE_W-1:0]  cfg_width,
    input  logic [SIZE_W-1:0]  cfg_height,
    input  logic               cfg_above,
    input  logic               cfg_enable,
    input  logic [SIZE_W-1:0]  base_width,
    input  logic [SIZE_W-1:0]  base_height,
    input  logic               frame_start,
    input  logic               pix_valid_in,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic               pix_base_clear,
    output logic               pix_valid_out,
    output logic               in_window,
    output logic               sel_overlay,
    output logic [3:0]         cfg_err
);
    win_t cand;
    win_t live;
    err_t chk_err;
    err_t err_q;

    ovl_cfg_check u_check (
        .place  (cfg_place),
        .width  (cfg_width),
        .height (cfg_height),
        .above  (cfg_above),
        .enable (cfg_enable),
        .base_w (base_width),
        .base_h (base_height),
        .cand   (cand),
        .err    (chk_err)
    );

    ovl_cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cand        (cand),
        .err_in      (chk_err),
        .frame_start (frame_start),
        .live        (live),
        .err_flags   (err_q)
    );

    ovl_pix_select u_sel (
        .clk            (clk),
        .rst_n          (rst_n),
        .live           (live),
        .pix_valid_in   (pix_valid_in),
        .pix_x          (pix_x),
        .pix_y          (pix_y),
        .pix_base_clear (pix_base_clear),
        .pix_valid_out  (pix_valid_out),
        .in_window      (in_window),
        .sel_overlay    (sel_overlay)
    );

    assign cfg_err = err_q;

    assert_live_fits_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live.en |-> (({2'b00, live.x0} + {1'b0, live.w}) <= {1'b0, base_width}));
endmodule

// File: tb/ovl_window_sel_test.sv
module ovl_window_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_place = '0;
    logic [10:0] cfg_width = '0;
    logic [10:0] cfg_height = '0;
    logic        cfg_above = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [10:0] base_width = 11'd640;
    logic [10:0] base_height = 11'd480;
    logic        frame_start = 1'b0;
    logic        pix_valid_in = 1'b0;
    logic [9:0]  pix_x = '0;
    logic [9:0]  pix_y = '0;
    logic        pix_base_clear = 1'b0;
    logic        pix_valid_out;
    logic        in_window;
    logic        sel_overlay;
    logic [3:0]  cfg_err;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ovl_window_sel uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int fmt, input int x, input int y, input int w,
                             input int h, input logic above, input logic en);
        @(negedge clk);
        cfg_place  = {9'h1A5, 3'(fmt), 10'(x), 10'(y)};
        cfg_width  = 11'(w);
        cfg_height = 11'(h);
        cfg_above  = above;
        cfg_enable = en;
        cfg_wr     = 1'b1;
        @(negedge clk);
        cfg_wr     = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic probe(input int px, input int py, input logic clr,
                         input logic ein, input logic esel, input string req);
        @(negedge clk);
        pix_valid_in   = 1'b1;
        pix_x          = 10'(px);
        pix_y          = 10'(py);
        pix_base_clear = clr;
        @(negedge clk);
        pix_valid_in   = 1'b0;
        chk({req, " in_window"}, in_window, ein);
        chk({req, " sel"}, sel_overlay, esel);
        chk({req, " valid"}, pix_valid_out, 1'b1);
    endtask

    task automatic t_reset();
        chk("R11 err", cfg_err, 4'h0);
        chk("R11 valid", pix_valid_out, 1'b0);
        probe(0, 0, 1'b1, 1'b0, 1'b0, "R11 no window");
        @(negedge clk);
        chk("R10 idle valid", pix_valid_out, 1'b0);
    endtask

    task automatic t_rgb_window();
        write_cfg(0, 100, 50, 64, 32, 1'b1, 1'b1);
        chk("R1 accept", cfg_err, 4'h0);
        probe(100, 50, 1'b0, 1'b0, 1'b0, "R7 before frame");
        frame();
        probe(100, 50, 1'b0, 1'b1, 1'b1, "R8 top-left");
        probe(163, 81, 1'b0, 1'b1, 1'b1, "R8 bottom-right");
        probe(164, 50, 1'b0, 1'b0, 1'b0, "R8 right edge");
        probe(99, 50, 1'b0, 1'b0, 1'b0, "R8 left edge");
        probe(100, 82, 1'b0, 1'b0, 1'b0, "R8 bottom edge");
        probe(100, 49, 1'b0, 1'b0, 1'b0, "R1 row field");
    endtask

    task automatic t_rejects();
        write_cfg(0, 101, 50, 64, 32, 1'b1, 1'b1);
        chk("R3 rgb odd x", cfg_err, 4'b0010);
        repeat (3) @(negedge clk);
        chk("R6 sticky", cfg_err, 4'b0010);
        write_cfg(1, 6, 0, 8, 8, 1'b1, 1'b1);
        chk("R3 yuv444 x=6", cfg_err, 4'b0010);
        write_cfg(4, 4, 0, 32, 8, 1'b1, 1'b1);
        chk("R3 yuv420 x=4", cfg_err, 4'b0010);
        write_cfg(4, 8, 0, 24, 8, 1'b1, 1'b1);
        chk("R4 yuv420 w=24", cfg_err, 4'b0100);
        write_cfg(3, 2, 0, 12, 8, 1'b1, 1'b1);
        chk("R4 yuv422 w=12", cfg_err, 4'b0100);
        write_cfg(5, 101, 0, 3, 8, 1'b1, 1'b1);
        chk("R2 bad code", cfg_err, 4'b0001);
        write_cfg(0, 578, 0, 64, 8, 1'b1, 1'b1);
        chk("R5 past edge", cfg_err, 4'b1000);
        write_cfg(0, 0, 0, 0, 8, 1'b1, 1'b1);
        chk("R5 zero width", cfg_err, 4'b1000);
        frame();
        probe(100, 50, 1'b0, 1'b1, 1'b1, "R6 window kept");
        probe(2, 0, 1'b0, 1'b0, 1'b0, "R6 reject not live");
    endtask

    task automatic t_edge_and_planar();
        write_cfg(0, 576, 448, 64, 32, 1'b1, 1'b1);
        chk("R5 exact edge", cfg_err, 4'h0);
        probe(100, 50, 1'b0, 1'b1, 1'b1, "R7 old until frame");
        frame();
        probe(639, 479, 1'b0, 1'b1, 1'b1, "R5 corner pixel");
        probe(575, 479, 1'b0, 1'b0, 1'b0, "R8 left of window");
        write_cfg(4, 16, 8, 32, 4, 1'b1, 1'b1);
        chk("R4 yuv420 w=32", cfg_err, 4'h0);
        frame();
        probe(47, 11, 1'b0, 1'b1, 1'b1, "R4 yuv420 live");
    endtask

    task automatic t_below_and_disable();
        write_cfg(0, 200, 100, 16, 16, 1'b0, 1'b1);
        frame();
        probe(205, 105, 1'b0, 1'b1, 1'b0, "R9 below opaque");
        probe(205, 105, 1'b1, 1'b1, 1'b1, "R9 below clear");
        write_cfg(0, 200, 100, 16, 16, 1'b1, 1'b0);
        frame();
        probe(205, 105, 1'b1, 1'b0, 1'b0, "R8 disabled");
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rgb_window();
        t_rejects();
        t_edge_and_planar();
        t_below_and_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule